// File: doc/BRIEF.md
# Half-Cycle Forwarded Clock Generator

This block produces the clock that is forwarded alongside a serialized data stream. For every core clock cycle it delivers two levels, one for the first half of the cycle and one for the second half, which a double-data-rate output cell downstream turns into a single pin waveform. Because the phase is counted in half core cycles, the forwarded clock can have an odd period in core cycles. It can also be shifted by half a core cycle, which gives a clock edge centred on each data bit.

The period is set by a 4-bit divider in whole core cycles. A divider of zero selects the longest period, 16 cycles. The starting phase is set by a 4-bit value in half-cycle steps. The generator moves forward only on cycles where the companion data shifter moves, which the shifter signals on `advance`. On cycles where the shifter stalls, the clock is frozen at its current level. While `enable` is low the generator is parked at its configured starting phase and drives both halves low. The next enabled, advancing cycle therefore launches the first half-cycle pair of a fresh waveform.

Top module: `hclk_gen`

## Requirements
- R1: A divider value of 0 gives a period of 16 core cycles. Starting from phase 0, the first 8 advancing cycles give the pair (0,0), the 9th gives (1,1), and 8 of the first 16 first-half levels are high.
- R2: Any divider value d from 1 to 15, odd or even, gives one full output period per d advancing cycles, which is 2d half-cycles, of which d are high. For d=5 and phase 0, the third advancing cycle gives the pair (first=0, second=1).
- R3: With phase 0 the clock starts low and first rises d half-cycles after the first advancing cycle. For d=3 the pairs are (0,0), (0,1), (1,1), (0,0).
- R4: Each step of the phase value starts the waveform one half core cycle later in its period. For d=2 and phase 1 the pairs are (0,1), (1,0), (0,1): the clock rises half a cycle after first data and falls one and a half cycles after it.
- R5: On an enabled cycle without `advance`, the phase does not move and both halves repeat the previous second-half level. The next advancing cycle continues the waveform where it stopped.
- R6: While `enable` is low both halves are 0 and the phase is reloaded from `phase`. After re-enabling, the waveform restarts from that phase.
- R7: The pair produced for an advancing cycle appears on the outputs after the clock edge that samples `advance`. For d=2 and phase 3, the first pair is (1,0).
- R8: Synchronous reset drives both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the generator; when low, park it at the starting phase |
| advance | input | 1 | High on cycles in which the data shifter shifts |
| divider | input | 4 | Period in core cycles; 0 selects 16 |
| phase | input | 4 | Starting phase in half core cycles; must be below twice the period |
| clk_first_half | output | 1 | Forwarded clock level for the first half of the cycle |
| clk_second_half | output | 1 | Forwarded clock level for the second half of the cycle |

## Verification
The directed patterns compare even and odd dividers (2, 3, 5) and the zero encoding. This separates a correct half-cycle modulus from one computed in whole cycles or one that treats zero as zero. Phase 0 and nonzero phases (1 and 3) show whether the starting count is loaded and whether the second half is taken one half-step later. Stall cycles placed in the middle of a period, and a disable followed by re-enable, show whether the counter freezes and reloads. A final stretch with pseudo-random `advance` and changing dividers is checked on every clock against a behavioural half-cycle model.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

  typedef struct packed {
    logic first;
    logic second;
  } hclk_pair_t;

  // Period in core cycles: a zero field selects the largest period 2**div_w.
  function automatic int period_cycles(input int div_val, input int div_w);
    return (div_val == 0) ? (1 << div_w) : div_val;
  endfunction

  // Add inc to a half-cycle count, folding once at modulus m.
  function automatic int wrap_add(input int cnt, input int inc, input int m);
    int s;
    s = cnt + inc;
    return (s >= m) ? (s - m) : s;
  endfunction

  // A half-cycle index in the upper half of the period is a high level.
  function automatic logic half_high(input int h, input int p);
    return (h >= p);
  endfunction

endpackage

// File: rtl/hclk_period_decode.sv
module hclk_period_decode #(
  parameter int DIV_W = 4,
  localparam int MOD_W = DIV_W + 2
) (
  input  logic [DIV_W-1:0] divider,
  output logic [MOD_W-1:0] period,
  output logic [MOD_W-1:0] modulus
);
  always_comb begin
    period  = MOD_W'(hclk_pkg::period_cycles(int'(divider), DIV_W));
    modulus = MOD_W'(period << 1);
  end
endmodule

// File: rtl/hclk_phase_counter.sv
module hclk_phase_counter #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 4,
  localparam int MOD_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             advance,
  input  logic [PH_W-1:0]  phase,
  input  logic [MOD_W-1:0] modulus,
  output logic [MOD_W-1:0] cnt,
  output logic             step_evt,
  output logic             wrap_evt
);
  logic [MOD_W-1:0] cnt_next;
  logic [MOD_W-1:0] phase_ext;

  always_comb begin
    phase_ext = MOD_W'(phase);
    step_evt  = enable && advance;
    cnt_next  = MOD_W'(hclk_pkg::wrap_add(int'(cnt), 2, int'(modulus)));
    wrap_evt  = step_evt && ((int'(cnt) + 2) >= int'(modulus));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!enable) begin
      cnt <= phase_ext;
    end else if (advance) begin
      cnt <= cnt_next;
    end
  end
endmodule

// File: rtl/hclk_level_map.sv
module hclk_level_map #(
  parameter int DIV_W = 4,
  localparam int MOD_W = DIV_W + 2
) (
  input  logic [MOD_W-1:0]   cnt,
  input  logic [MOD_W-1:0]   period,
  input  logic [MOD_W-1:0]   modulus,
  output hclk_pkg::hclk_pair_t lvl
);
  int h_second;

  always_comb begin
    h_second   = hclk_pkg::wrap_add(int'(cnt), 1, int'(modulus));
    lvl.first  = hclk_pkg::half_high(int'(cnt), int'(period));
    lvl.second = hclk_pkg::half_high(h_second, int'(period));
  end
endmodule

// File: rtl/hclk_gen.sv
module hclk_gen #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             advance,
  input  logic [DIV_W-1:0] divider,
  input  logic [PH_W-1:0]  phase,
  output logic             clk_first_half,
  output logic             clk_second_half
);
  localparam int MOD_W = DIV_W + 2;

  logic [MOD_W-1:0]     period;
  logic [MOD_W-1:0]     modulus;
  logic [MOD_W-1:0]     cnt;
  logic                 step_evt;
  logic                 wrap_evt;
  hclk_pkg::hclk_pair_t lvl;
  hclk_pkg::hclk_pair_t out_q;

  hclk_period_decode #(.DIV_W(DIV_W)) u_decode (
    .divider (divider),
    .period  (period),
    .modulus (modulus)
  );

  hclk_phase_counter #(.DIV_W(DIV_W), .PH_W(PH_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .advance  (advance),
    .phase    (phase),
    .modulus  (modulus),
    .cnt      (cnt),
    .step_evt (step_evt),
    .wrap_evt (wrap_evt)
  );

  hclk_level_map #(.DIV_W(DIV_W)) u_map (
    .cnt     (cnt),
    .period  (period),
    .modulus (modulus),
    .lvl     (lvl)
  );

  // Output pair register: launch on advancing cycles, freeze on stalls.
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      out_q <= '0;
    end else if (step_evt) begin
      out_q <= lvl;
    end else begin
      out_q.first  <= out_q.second;
      out_q.second <= out_q.second;
    end
  end

  assign clk_first_half  = out_q.first;
  assign clk_second_half = out_q.second;
endmodule

// File: rtl/hclk_gen_checker.sv
module hclk_gen_checker #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 4,
  localparam int MOD_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             advance,
  input logic [DIV_W-1:0] divider,
  input logic [PH_W-1:0]  phase,
  input logic             clk_first_half,
  input logic             clk_second_half,
  input logic [MOD_W-1:0] cnt,
  input logic [MOD_W-1:0] modulus,
  input logic             step_evt,
  input logic             wrap_evt
);
  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (!clk_first_half && !clk_second_half));

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!clk_first_half && !clk_second_half));

  assert_reload_phase_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == MOD_W'($past(phase))));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (enable && !advance) |=> ($stable(cnt) && $stable(clk_second_half)
                              && clk_first_half == clk_second_half));

  assert_step_only_when_shift_R5: assert property (@(posedge clk) disable iff (rst)
    step_evt |-> (enable && advance));

  assert_zero_div_R1: assert property (@(posedge clk) disable iff (rst)
    (divider == '0) |-> (int'(modulus) == (2 << DIV_W)));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (step_evt && cnt < modulus && $stable(divider)) |=> (cnt < $past(modulus)));

  assert_wrap_back_R2: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && $stable(divider)) |=> (cnt <= $past(cnt)));
endmodule

bind hclk_gen hclk_gen_checker #(.DIV_W(DIV_W), .PH_W(PH_W)) u_hclk_gen_checker (
  .clk             (clk),
  .rst             (rst),
  .enable          (enable),
  .advance         (advance),
  .divider         (divider),
  .phase           (phase),
  .clk_first_half  (clk_first_half),
  .clk_second_half (clk_second_half),
  .cnt             (cnt),
  .modulus         (modulus),
  .step_evt        (step_evt),
  .wrap_evt        (wrap_evt)
);

// File: tb/test_hclk_gen.sv
`timescale 1ns/1ps
module test_hclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       advance = 1'b0;
  logic [3:0] divider = 4'd2;
  logic [3:0] phase = 4'd0;
  logic       clk_first_half;
  logic       clk_second_half;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R8";
  int    hcount = 0;
  logic  exp_f = 1'b0;
  logic  exp_s = 1'b0;
  bit    done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hclk_gen i_hclk_gen (
    .clk             (clk),
    .rst             (rst),
    .enable          (enable),
    .advance         (advance),
    .divider         (divider),
    .phase           (phase),
    .clk_first_half  (clk_first_half),
    .clk_second_half (clk_second_half)
  );

  // Behavioural reference: absolute half-cycle count folded per step.
  always @(posedge clk) begin
    int p;
    int m;
    p = (divider == 0) ? 16 : int'(divider);
    m = 2 * p;
    if (rst) begin
      exp_f = 0; exp_s = 0; hcount = 0;
    end else if (!enable) begin
      exp_f = 0; exp_s = 0; hcount = int'(phase);
    end else if (advance) begin
      exp_f = ((hcount % m) / p) == 1;
      exp_s = (((hcount + 1) % m) / p) == 1;
      hcount = (hcount + 2) % m;
    end else begin
      exp_f = exp_s;
    end
  end

  // Every-cycle comparison, sampled away from the edge.
  always @(posedge clk) begin
    #5;
    if (!done) begin
      n_checks++;
      if (clk_first_half !== exp_f || clk_second_half !== exp_s) begin
        n_errors++;
        $display("FAIL %s cycle compare: actual=(%0b,%0b) expected=(%0b,%0b)",
                 cur_req, clk_first_half, clk_second_half, exp_f, exp_s);
      end
    end
  end

  task automatic tick(input logic en, input logic adv);
    @(negedge clk);
    enable  = en;
    advance = adv;
    @(posedge clk);
    #6;
  endtask

  task automatic chk(input logic f, input logic s, input string tag);
    n_checks++;
    if (clk_first_half !== f || clk_second_half !== s) begin
      n_errors++;
      $display("FAIL %s: actual=(%0b,%0b) expected=(%0b,%0b)",
               tag, clk_first_half, clk_second_half, f, s);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [3:0] d, input logic [3:0] ph);
    @(negedge clk);
    divider = d;
    phase   = ph;
    tick(1'b0, 1'b0);
  endtask

  initial begin
    int highs;
    logic [7:0] lfsr;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk(1'b0, 1'b0, "R8 reset low");
    @(negedge clk); rst = 1'b0;

    // R4: divider 2, phase 1
    cur_req = "R4";
    configure(4'd2, 4'd1);
    tick(1'b1, 1'b1); chk(1'b0, 1'b1, "R4 pair0");
    tick(1'b1, 1'b1); chk(1'b1, 1'b0, "R4 pair1");
    tick(1'b1, 1'b1); chk(1'b0, 1'b1, "R4 pair2");

    // R5: stalls hold, then continue
    cur_req = "R5";
    tick(1'b1, 1'b0); chk(1'b1, 1'b1, "R5 stall0");
    tick(1'b1, 1'b0); chk(1'b1, 1'b1, "R5 stall1");
    tick(1'b1, 1'b1); chk(1'b1, 1'b0, "R5 resume");

    // R6: disable parks low, re-enable restarts from phase
    cur_req = "R6";
    tick(1'b0, 1'b1); chk(1'b0, 1'b0, "R6 disabled low");
    tick(1'b1, 1'b1); chk(1'b0, 1'b1, "R6 restart at phase");

    // R3: divider 3, phase 0
    cur_req = "R3";
    configure(4'd3, 4'd0);
    tick(1'b1, 1'b1); chk(1'b0, 1'b0, "R3 p0");
    tick(1'b1, 1'b1); chk(1'b0, 1'b1, "R3 p1 rise");
    tick(1'b1, 1'b1); chk(1'b1, 1'b1, "R3 p2");
    tick(1'b1, 1'b1); chk(1'b0, 1'b0, "R3 p3 wrap");

    // R2: odd divider 5
    cur_req = "R2";
    configure(4'd5, 4'd0);
    highs = 0;
    for (int i = 0; i < 5; i++) begin
      tick(1'b1, 1'b1);
      highs += int'(clk_first_half) + int'(clk_second_half);
      if (i == 2) chk(1'b0, 1'b1, "R2 odd mid-cycle rise");
    end
    chk_int(highs, 5, "R2 high halves per period");

    // R1: divider 0 means 16
    cur_req = "R1";
    configure(4'd0, 4'd0);
    highs = 0;
    for (int i = 0; i < 16; i++) begin
      tick(1'b1, 1'b1);
      highs += int'(clk_first_half);
      if (i == 7) chk(1'b0, 1'b0, "R1 eighth still low");
      if (i == 8) chk(1'b1, 1'b1, "R1 ninth high");
    end
    chk_int(highs, 8, "R1 first-half highs over 16");

    // R7: first pair lands after the sampling edge
    cur_req = "R7";
    configure(4'd2, 4'd3);
    chk(1'b0, 1'b0, "R7 before launch");
    tick(1'b1, 1'b1); chk(1'b1, 1'b0, "R7 first pair");

    // Mixed stalls and dividers against the model
    cur_req = "R5";
    lfsr = 8'h5a;
    for (int k = 0; k < 6; k++) begin
      configure(4'(k * 3 + 1), 4'(k));
      for (int i = 0; i < 60; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick(1'b1, lfsr[0]);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule